// File: doc/BRIEF.md
# Mode-Gated External Interrupt Edge Detector

This block turns external interrupt pins into request flags. It serves two kinds of source. The two request pins can each detect either a falling or a rising edge. The eight wakeup pins detect falling edges only. Each raw pin first goes through a two-flop synchronizer. It is then gated by its own pin-function enable bit. While the function is off, the gated signal is forced high. The edge detector compares that gated level with the level it held on the previous clock. Because of this, switching a function bit while the pin is low can itself create an edge and set a flag. Software must allow for that.

Each source has its own flag. A flag stays set until software clears it by writing 0 to its bit. Writing 1 to a bit does nothing, so software can never set a flag. A small guard state machine ignores any clear that comes on the cycle right after a mode-register write. Every source also has a mask bit. A masked source still sets its flag, but only unmasked flags drive the combined interrupt output.

The guard machine has two states. In GRD_OPEN, clears are accepted. In GRD_HOLD, clears are ignored. A mode write in any cycle causes the transition to GRD_HOLD (named ENTER_HOLD). A cycle in GRD_HOLD with no mode write causes the transition back to GRD_OPEN (named REOPEN). A further mode write while in GRD_HOLD keeps the machine in GRD_HOLD (named STAY_HOLD).

Top module: `extint_edge_unit`

## Requirements
- R1: After reset, every flag reads 0, irq_out is 0, and every mode, edge-select and mask bit is 0.
- R2: Flag bits 0 and 1 belong to request pins 0 and 1. With its mode bit set, a request pin sets its flag on a falling edge when its edge bit is 0, and on a rising edge when its edge bit is 1. The opposite edge is ignored.
- R3: If a request pin's mode bit changes from 0 to 1 while the synchronized pin is low and its edge bit is 0, its flag sets on the second clock edge after the write.
- R4: If a request pin's mode bit changes from 1 to 0 while the synchronized pin is low and its edge bit is 1, its flag sets. If the same pin is enabled while low with edge bit 1, its flag stays clear.
- R5: Flag bits 2 to 9 belong to wakeup pins 0 to 7. With its mode bit set, a wakeup pin sets its flag on a falling edge only.
- R6: If a wakeup pin's mode bit changes from 0 to 1 while the synchronized pin is low, its flag sets.
- R7: While a source's mode bit is 0, no activity on its pin sets its flag.
- R8: A clear write with data bit 0 clears that flag. A data bit of 1 leaves the flag unchanged, so software can never set a flag.
- R9: A clear write on the cycle right after a mode write has no effect. A clear write with at least one cycle between it and the mode write takes effect.
- R10: irq_out is 1 exactly when some flag is set and its mask bit is 1. A masked source still sets its flag.
- R11: If an edge and an accepted clear land on the same flag in the same cycle, the flag ends up set.
- R12: A pin change made between two clock edges is first visible in its flag after the third rising edge that follows the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_irq | input | 2 | Raw request pins |
| pin_wkp | input | 8 | Raw wakeup pins |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 10 | Pin-function enables: bits 1:0 request pins, bits 9:2 wakeup pins |
| edge_wr | input | 1 | Edge-select write strobe |
| edge_wdata | input | 2 | Per request pin: 1 selects rising, 0 selects falling |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 10 | Mask enables, same bit layout as the flags |
| flag_clr_wr | input | 1 | Flag clear write strobe |
| flag_clr_wdata | input | 10 | A 0 bit clears that flag; a 1 bit leaves it unchanged |
| flag_q | output | 10 | Request flags |
| irq_out | output | 1 | OR of the flags whose mask bit is set |

## Verification
The bench targets the edges created by mode switching. It enables a request pin while the pin is low, under each edge polarity. A design that fed the raw pin to the detector would miss the request that should be raised, and one with the polarity reversed would raise a request it should not. It places a clear on the cycle right after a mode write and again one cycle later. A missing guard would drop the flag too early, and a guard held too long would keep the flag. It also lands an edge on the same cycle as an accepted clear, and counts the exact three-edge latency from pin to flag. A design that let the clear win, or that used one synchronizer stage too few or too many, would fail there.

// File: rtl/extint_pkg.sv
package extint_pkg;
    parameter int NUM_IRQ = 2;
    parameter int NUM_WKP = 8;
    localparam int NSRC   = NUM_IRQ + NUM_WKP;

    typedef enum logic {
        GRD_OPEN = 1'b0,
        GRD_HOLD = 1'b1
    } guard_state_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '1;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/extint_edge_cell.sv
module extint_edge_cell #(
    parameter bit FIXED_FALL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic func_en,
    input  logic sel_rise,
    output logic hit
);
    logic gated;
    logic gated_prev;
    logic rise_ev;
    logic fall_ev;
    logic use_rise;

    // disabled function forces the line high
    assign gated = func_en ? pin_s : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gated_prev <= 1'b1;
        else        gated_prev <= gated;
    end

    assign rise_ev = !gated_prev &&  gated;
    assign fall_ev =  gated_prev && !gated;

    generate
        if (FIXED_FALL) begin : g_fall_only
            assign use_rise = 1'b0 & sel_rise;
        end else begin : g_selectable
            assign use_rise = sel_rise;
        end
    endgenerate

    assign hit = use_rise ? rise_ev : fall_ev;
endmodule

// File: rtl/extint_clr_guard.sv
module extint_clr_guard
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    output logic clr_open,
    output logic guard_hold
);
    guard_state_e state_q;
    guard_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GRD_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GRD_OPEN: if (mode_wr) state_d = GRD_HOLD;  // ENTER_HOLD
            GRD_HOLD: if (!mode_wr) state_d = GRD_OPEN; // REOPEN, else STAY_HOLD
            default:  state_d = GRD_OPEN;
        endcase
    end

    always_comb begin
        clr_open   = 1'b0;
        guard_hold = 1'b0;
        unique case (state_q)
            GRD_OPEN: clr_open   = 1'b1;
            GRD_HOLD: guard_hold = 1'b1;
            default:  clr_open   = 1'b1;
        endcase
    end
endmodule

// File: rtl/extint_edge_unit.sv
module extint_edge_unit
    import extint_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] pin_irq,
    input  logic [NUM_WKP-1:0] pin_wkp,
    input  logic               mode_wr,
    input  logic [NSRC-1:0]    mode_wdata,
    input  logic               edge_wr,
    input  logic [NUM_IRQ-1:0] edge_wdata,
    input  logic               mask_wr,
    input  logic [NSRC-1:0]    mask_wdata,
    input  logic               flag_clr_wr,
    input  logic [NSRC-1:0]    flag_clr_wdata,
    output logic [NSRC-1:0]    flag_q,
    output logic               irq_out
);
    logic [NSRC-1:0]    pins_raw;
    logic [NSRC-1:0]    pins_s;
    logic [NSRC-1:0]    mode_q;
    logic [NSRC-1:0]    mask_q;
    logic [NUM_IRQ-1:0] edge_q;
    logic [NSRC-1:0]    set_vec;
    logic [NSRC-1:0]    clr_vec;
    logic [NSRC-1:0]    flag_d;
    logic               clr_open;
    logic               guard_hold;

    assign pins_raw = {pin_wkp, pin_irq};

    extint_sync #(.W(NSRC), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            mask_q <= '0;
            edge_q <= '0;
        end else begin
            if (mode_wr) mode_q <= mode_wdata;
            if (mask_wr) mask_q <= mask_wdata;
            if (edge_wr) edge_q <= edge_wdata;
        end
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            if (i < NUM_IRQ) begin : g_irq
                extint_edge_cell #(.FIXED_FALL(1'b0)) u_cell (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .pin_s    (pins_s[i]),
                    .func_en  (mode_q[i]),
                    .sel_rise (edge_q[i]),
                    .hit      (set_vec[i])
                );
            end else begin : g_wkp
                extint_edge_cell #(.FIXED_FALL(1'b1)) u_cell (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .pin_s    (pins_s[i]),
                    .func_en  (mode_q[i]),
                    .sel_rise (1'b0),
                    .hit      (set_vec[i])
                );
            end
        end
    endgenerate

    extint_clr_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .clr_open   (clr_open),
        .guard_hold (guard_hold)
    );

    assign clr_vec = (flag_clr_wr && clr_open) ? ~flag_clr_wdata : '0;
    assign flag_d  = (flag_q & ~clr_vec) | set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign irq_out = |(flag_q & mask_q);
endmodule

// File: rtl/extint_edge_unit_chk.sv
module extint_edge_unit_chk
    import extint_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            mode_wr,
    input logic            flag_clr_wr,
    input logic [NSRC-1:0] flag_clr_wdata,
    input logic [NSRC-1:0] flag_q,
    input logic [NSRC-1:0] mask_q,
    input logic            irq_out,
    input logic            guard_hold
);
    assert_reset_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_q == '0));

    assert_ones_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_wr && (&flag_clr_wdata)) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    assert_guard_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> guard_hold);

    assert_clr_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_wr) && flag_clr_wr) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|flag_q));

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> ((flag_q & mask_q) == '0));
endmodule

bind extint_edge_unit extint_edge_unit_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_wr        (mode_wr),
    .flag_clr_wr    (flag_clr_wr),
    .flag_clr_wdata (flag_clr_wdata),
    .flag_q         (flag_q),
    .mask_q         (mask_q),
    .irq_out        (irq_out),
    .guard_hold     (guard_hold)
);

// File: tb/extint_edge_unit_tb.sv
module extint_edge_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin_irq = 2'b11;
    logic [7:0] pin_wkp = 8'hFF;
    logic       mode_wr = 0, edge_wr = 0, mask_wr = 0, flag_clr_wr = 0;
    logic [9:0] mode_wdata = '0, mask_wdata = '0, flag_clr_wdata = '1;
    logic [1:0] edge_wdata = '0;
    logic [9:0] flag_q;
    logic       irq_out;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    extint_edge_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pin_irq(pin_irq), .pin_wkp(pin_wkp),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .edge_wr(edge_wr),
        .edge_wdata(edge_wdata), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .flag_clr_wr(flag_clr_wr), .flag_clr_wdata(flag_clr_wdata),
        .flag_q(flag_q), .irq_out(irq_out)
    );

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_mode(input logic [9:0] v);
        mode_wr = 1; mode_wdata = v; tick(); mode_wr = 0;
    endtask

    task automatic wr_edge(input logic [1:0] v);
        edge_wr = 1; edge_wdata = v; tick(); edge_wr = 0;
    endtask

    task automatic wr_mask(input logic [9:0] v);
        mask_wr = 1; mask_wdata = v; tick(); mask_wr = 0;
    endtask

    task automatic clr(input logic [9:0] v);
        flag_clr_wr = 1; flag_clr_wdata = v; tick(); flag_clr_wr = 0; flag_clr_wdata = '1;
    endtask

    task automatic clear_all();
        tick(2);
        clr(10'h000);
    endtask

    task automatic t_reset();
        check("R1 flags", flag_q, 0);
        check("R1 irq_out", irq_out, 0);
        wr_mask(10'h3FF);
        pin_irq = 2'b00; pin_wkp = 8'h00; tick(4);
        check("R1 modes off", flag_q, 0);
        pin_irq = 2'b11; pin_wkp = 8'hFF; tick(4);
        wr_mask(10'h000);
    endtask

    task automatic t_irq_fall_latency();
        wr_edge(2'b00); wr_mode(10'h001); tick(3);
        pin_irq[0] = 0;
        tick(2);
        check("R12 not yet", flag_q, 0);
        tick(1);
        check("R12/R2 fall sets", flag_q, 10'h001);
        clear_all();
        pin_irq[0] = 1; tick(4);
        check("R2 rise ignored edge0", flag_q, 0);
        wr_mode(10'h000); clear_all();
    endtask

    task automatic t_irq_rise();
        wr_edge(2'b10); pin_irq[1] = 0; tick(3);
        wr_mode(10'h002); tick(2);
        check("R4 enable low rise-sel no flag", flag_q, 0);
        pin_irq[1] = 1; tick(3);
        check("R2 rise sets", flag_q, 10'h002);
        clear_all();
        pin_irq[1] = 0; tick(4);
        check("R2 fall ignored edge1", flag_q, 0);
        wr_mode(10'h000); clear_all();
        pin_irq[1] = 1; tick(3);
    endtask

    task automatic t_mode_on_low();
        wr_edge(2'b00); pin_irq[0] = 0; tick(3);
        wr_mode(10'h001);
        check("R3 not after one edge", flag_q, 0);
        tick(1);
        check("R3 mode on low sets", flag_q, 10'h001);
        wr_mode(10'h000); clear_all();
        pin_irq[0] = 1; tick(3);
    endtask

    task automatic t_mode_off_low();
        wr_edge(2'b10); pin_irq[1] = 0; tick(3);
        wr_mode(10'h002); tick(2);
        check("R4 pre", flag_q, 0);
        wr_mode(10'h000); tick(1);
        check("R4 mode off low sets", flag_q, 10'h002);
        clear_all();
        pin_irq[1] = 1; tick(3);
        wr_edge(2'b00);
    endtask

    task automatic t_wakeup();
        wr_mode(10'h3FC); tick(3);
        pin_wkp[3] = 0; tick(3);
        check("R5 wkp3 fall", flag_q, 10'h020);
        clear_all();
        pin_wkp[3] = 1; tick(4);
        check("R5 wkp3 rise ignored", flag_q, 0);
        wr_mode(10'h000); pin_wkp[5] = 0; tick(3);
        wr_mode(10'h080); tick(1);
        check("R6 wkp5 mode on low", flag_q, 10'h080);
        wr_mode(10'h000); clear_all();
        pin_wkp[5] = 1; tick(3);
    endtask

    task automatic t_disabled();
        pin_wkp = 8'h00; pin_irq = 2'b00; tick(4);
        pin_wkp = 8'hFF; pin_irq = 2'b11; tick(4);
        check("R7 disabled pins quiet", flag_q, 0);
    endtask

    task automatic t_clear();
        wr_mode(10'h004); tick(3);
        pin_wkp[0] = 0; tick(3);
        check("R8 pre", flag_q, 10'h004);
        tick(1);
        clr(10'h3FF);
        check("R8 ones keep", flag_q, 10'h004);
        clr(10'h3FB);
        check("R8 zero clears", flag_q, 0);
        clr(10'h3FF);
        check("R8 no sw set", flag_q, 0);
        pin_wkp[0] = 1; tick(3);
    endtask

    task automatic t_guard();
        pin_wkp[0] = 0; tick(3);
        check("R9 pre", flag_q, 10'h004);
        wr_mode(10'h004);
        clr(10'h000);
        check("R9 blocked right after mode wr", flag_q, 10'h004);
        wr_mode(10'h004);
        tick(1);
        clr(10'h000);
        check("R9 clear after gap", flag_q, 0);
        pin_wkp[0] = 1; tick(3);
        wr_mode(10'h000); tick(2);
    endtask

    task automatic t_mask();
        wr_mode(10'h200); tick(3);
        pin_wkp[7] = 0; tick(3);
        check("R10 masked flag set", flag_q, 10'h200);
        check("R10 masked irq low", irq_out, 0);
        wr_mask(10'h200);
        check("R10 unmasked irq high", irq_out, 1);
        clr(10'h000);
        check("R10 irq drops on clear", irq_out, 0);
        wr_mask(10'h000);
        pin_wkp[7] = 1; tick(3);
        wr_mode(10'h000); tick(2);
    endtask

    task automatic t_same_cycle();
        wr_edge(2'b00); wr_mode(10'h001); tick(3);
        pin_irq[0] = 0;
        tick(2);
        flag_clr_wr = 1; flag_clr_wdata = 10'h000;
        tick(1);
        flag_clr_wr = 0; flag_clr_wdata = '1;
        check("R11 set beats clear", flag_q, 10'h001);
        clear_all();
        pin_irq[0] = 1; tick(3);
        wr_mode(10'h000); tick(2);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        t_reset();
        t_irq_fall_latency();
        t_irq_rise();
        t_mode_on_low();
        t_mode_off_low();
        t_wakeup();
        t_disabled();
        t_clear();
        t_guard();
        t_mask();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule